// File: doc/BRIEF.md
# Checkpoint Beep-Code Sequencer

This block turns an 8-bit progress checkpoint into a pattern of audible beep groups, so that a fault can be located before any display is working. A one-cycle start strobe, given while the block is idle, captures the checkpoint. The block then plays four groups of beeps. Each group comes from one 2-bit field of the value, taken from the most significant field down. A group has one more beep than its field value, so it has one to four beeps.

Beeps within a group are separated by a short silence. Groups are separated by a longer silence, so a listener can hear where one group ends. The only audio output is a speaker-enable level. Tone generation is done elsewhere. Busy and done status outputs tell the surrounding logic when the speaker is in use. All durations are clock-cycle parameters.

Top module: `beep_code_seq`

## Requirements
- R1: When start is high in a cycle where busy is low, the code input is captured at that clock edge. From the next cycle, busy is high and spk_en is high, which is the first beep.
- R2: Bits [7:6] of the captured code are played first, then [5:4], then [3:2], then [1:0]. A field of value v plays v+1 beeps, so 00 gives one beep and 11 gives four.
- R3: Each beep holds spk_en high for BEEP_ON consecutive cycles. Consecutive beeps inside one group are separated by exactly BEEP_OFF low cycles.
- R4: Consecutive groups are separated by exactly GROUP_GAP low cycles of spk_en. GROUP_GAP is meant to be larger than BEEP_OFF.
- R5: In the cycle right after the last beep of the fourth group ends, done is high for exactly one cycle. In that same cycle busy and spk_en are low, and no gap follows the last group.
- R6: A start received while busy is high is ignored. The running pattern, the captured code and the end time do not change.
- R7: A synchronous reset (rst high at a clock edge) drives busy, done and spk_en low from the next cycle and abandons any pattern in progress.
- R8: Checkpoint 0x4B sounds 2-1-3-4, 0x16 sounds 1-2-2-3, 0x20 sounds 1-3-1-1, 0x22 sounds 1-3-1-3, 0x28 sounds 1-3-3-1 and 0x2C sounds 1-3-4-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Capture strobe, acted on only while idle |
| code | input | 8 | Checkpoint value to be sounded |
| spk_en | output | 1 | Speaker enable, high while a beep sounds |
| busy | output | 1 | High from capture until the last beep ends |
| done | output | 1 | One-cycle pulse when the pattern has finished |

## Verification
A wrong group index or a wrong beep counter shows up at spk_en within one beep period. It appears as an extra or missing beep, or as a field played out of order. A duration counter that is off by one moves every later edge of spk_en by a cycle, so comparing the output cycle by cycle against a pattern worked out from the requirements catches it at the first affected edge. A code register that is not protected while busy changes the groups that follow a stray start. The pattern is therefore also checked with a start pulse arriving in the middle of a run.

// File: rtl/beep_code_seq.sv
module beep_code_seq #(
  parameter int BEEP_ON   = 4,
  parameter int BEEP_OFF  = 3,
  parameter int GROUP_GAP = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] code,
  output logic       spk_en,
  output logic       busy,
  output logic       done
);

  localparam int MAX_D = (BEEP_ON > BEEP_OFF) ?
                         ((BEEP_ON > GROUP_GAP) ? BEEP_ON : GROUP_GAP) :
                         ((BEEP_OFF > GROUP_GAP) ? BEEP_OFF : GROUP_GAP);
  localparam int TW = (MAX_D > 1) ? $clog2(MAX_D) : 1;
  localparam logic [TW-1:0] ON_L  = TW'(BEEP_ON - 1);
  localparam logic [TW-1:0] OFF_L = TW'(BEEP_OFF - 1);
  localparam logic [TW-1:0] GAP_L = TW'(GROUP_GAP - 1);

  typedef enum logic [1:0] {S_IDLE, S_ON, S_OFF, S_GAP} state_t;

  state_t        state;
  logic [7:0]    code_q;
  logic [1:0]    grp;
  logic [1:0]    left;
  logic [TW-1:0] tmr;
  logic [1:0]    next_field;

  assign next_field = code_q[{~(grp + 2'd1), 1'b0} +: 2];
  assign spk_en     = (state == S_ON);
  assign busy       = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      code_q <= '0;
      grp    <= '0;
      left   <= '0;
      tmr    <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          code_q <= code;
          grp    <= '0;
          left   <= code[7:6];
          tmr    <= ON_L;
          state  <= S_ON;
        end
        S_ON: begin
          if (tmr != '0) tmr <= tmr - 1'b1;
          else if (left != '0) begin
            left  <= left - 1'b1;
            tmr   <= OFF_L;
            state <= S_OFF;
          end else if (grp != 2'd3) begin
            tmr   <= GAP_L;
            state <= S_GAP;
          end else begin
            state <= S_IDLE;
            done  <= 1'b1;
          end
        end
        S_OFF: begin
          if (tmr != '0) tmr <= tmr - 1'b1;
          else begin
            tmr   <= ON_L;
            state <= S_ON;
          end
        end
        default: begin
          if (tmr != '0) tmr <= tmr - 1'b1;
          else begin
            grp   <= grp + 2'd1;
            left  <= next_field;
            tmr   <= ON_L;
            state <= S_ON;
          end
        end
      endcase
    end
  end

  assert_start_capture_R1: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy && spk_en));

  assert_code_held_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (code_q == $past(code_q)));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !spk_en));

  assert_beep_inside_run_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(spk_en) |-> busy);

  assert_reset_clears_R7: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !spk_en && !done));

endmodule

// File: tb/beep_code_seq_bench.sv
module beep_code_seq_bench;
  localparam int P_ON = 3, P_OFF = 2, P_GAP = 6;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [7:0] code = '0;
  logic spk_en, busy, done;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  beep_code_seq #(.BEEP_ON(P_ON), .BEEP_OFF(P_OFF), .GROUP_GAP(P_GAP)) u_beep_code_seq (
    .clk(clk), .rst(rst), .start(start), .code(code),
    .spk_en(spk_en), .busy(busy), .done(done));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_code(input logic [7:0] c, input string req, input bit poke);
    bit pat[0:255];
    int n = 0, beeps = 0, rises = 0, mism = 0, first_bad = -1;
    bit prev = 1'b0;
    for (int g = 0; g < 4; g++) begin
      int k = ((c >> (6 - 2 * g)) & 3) + 1;
      for (int b = 0; b < k; b++) begin
        for (int t = 0; t < P_ON; t++) pat[n++] = 1'b1;
        beeps++;
        if (b != k - 1) for (int t = 0; t < P_OFF; t++) pat[n++] = 1'b0;
      end
      if (g != 3) for (int t = 0; t < P_GAP; t++) pat[n++] = 1'b0;
    end
    @(negedge clk); code = c; start = 1'b1;
    @(negedge clk); start = 1'b0; code = ~c;
    for (int i = 0; i < n; i++) begin
      if (poke && i == 5) begin start = 1'b1; code = 8'hFF; end
      if (poke && i == 6) start = 1'b0;
      if (spk_en !== pat[i] || busy !== 1'b1) begin
        mism++;
        if (first_bad < 0) first_bad = i;
      end
      if (spk_en && !prev) rises++;
      prev = spk_en;
      @(negedge clk);
    end
    check(mism == 0, req, "spk_en/busy pattern mismatches (first bad cycle in log)", mism, 0);
    if (mism != 0) $display("  first mismatching cycle index %0d", first_bad);
    check(rises == beeps, "R2", "beep count", rises, beeps);
    check(done && !busy && !spk_en, "R5", "done/busy/spk at end {d,b,s}",
          {29'd0, done, busy, spk_en}, 4);
    @(negedge clk);
    check(!done && !busy, "R5", "done single cycle, stays idle {d,b}",
          {30'd0, done, busy}, 0);
  endtask

  task automatic test_reset_state;
    check(!spk_en && !busy && !done, "R7", "outputs after reset {s,b,d}",
          {29'd0, spk_en, busy, done}, 0);
  endtask

  task automatic test_known_codes;
    run_code(8'h4B, "R8", 1'b0);
    run_code(8'h16, "R8", 1'b0);
    run_code(8'h20, "R8", 1'b0);
    run_code(8'h22, "R8", 1'b0);
    run_code(8'h28, "R8", 1'b0);
    run_code(8'h2C, "R8", 1'b0);
  endtask

  task automatic test_extremes;
    run_code(8'h00, "R3", 1'b0);
    run_code(8'hFF, "R4", 1'b0);
    run_code(8'hE4, "R2", 1'b0);
  endtask

  task automatic test_start_while_busy;
    run_code(8'h1B, "R6", 1'b1);
  endtask

  task automatic test_capture;
    @(negedge clk); code = 8'h00; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy && spk_en, "R1", "busy&spk one cycle after start",
          {30'd0, busy, spk_en}, 3);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic test_mid_reset;
    @(negedge clk); code = 8'hFF; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(!spk_en && !busy && !done, "R7", "outputs after mid-run reset {s,b,d}",
          {29'd0, spk_en, busy, done}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy && !spk_en, "R7", "stays idle after reset {b,s}",
          {30'd0, busy, spk_en}, 0);
    run_code(8'h4B, "R1", 1'b0);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    test_reset_state();
    test_capture();
    test_known_codes();
    test_extremes();
    test_start_while_busy();
    test_mid_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule